// File: doc/BRIEF.md
# Pulse-Interval Downlink Modulator

This block turns a stream of downlink symbols into the carrier-enable line of a 125 kHz low-frequency reader that writes to a rewritable tag. Each symbol is carried by the time the field stays on. A fixed field-off gap follows every on-period, and the tag tells symbols apart by measuring the on-time between gaps. All durations are counted in ticks of an external one-microsecond strobe. A single down-counter is reloaded at every phase change.

A command begins with a start request and a two-bit timing mode, which are latched together. The block powers the tag with a long field-on period and then opens a start gap. In the long-reference mode it also sends one extended reference pulse before the first symbol. It then takes symbols through a valid/ready handshake, and the source flags the final symbol as last. After the gap that follows the last symbol, the field is left on, busy drops and done pulses. The tag's answer, analog drive and sample capture are handled elsewhere.

Top module: `pim_downlink`

## Requirements
- R1: Out of reset, `field_en`, `busy`, `done` and `sym_ready` are all low.
- R2: A start request seen while idle raises `busy` and holds the field on for `PWRUP_US` ticks (default 5000). The field is then off for a start gap of 248 ticks.
- R3: The on-period of every symbol and of the long reference is followed by a field-off write gap of 160 ticks.
- R4: In fixed-bit mode (mode code 2'b00), only `sym_val[0]` is used: a 0 holds the field on for 144 ticks and a 1 for 400 ticks.
- R5: In leading-zero mode (code 2'b10), only `sym_val[0]` is used: a 0 holds the field on for 144 ticks and a 1 for 320 ticks.
- R6: In one-of-four mode (code 2'b11), `sym_val[1:0]` values 00, 01, 10 and 11 hold the field on for 144, 272, 400 and 528 ticks.
- R7: In long-reference mode (code 2'b01), one on-pulse of 1232 ticks (the 0-symbol time plus 1088) and its write gap come straight after the start gap, before any symbol. Symbols then use the fixed-bit timing.
- R8: Phases advance only on cycles where `tick_us` is high. With a sparse strobe, the tick counts are unchanged and the phases stretch in clock cycles.
- R9: `sym_ready` is high only at the final tick of the start gap or of a write gap that does not follow the last symbol, or while waiting for a late symbol. It is never high while idle or during an on-period.
- R10: After the write gap of the symbol flagged `sym_last`, `busy` falls and `done` is high for exactly one cycle. `field_en` then stays high until the next command.
- R11: A start request or a mode change while busy has no effect on the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond timebase strobe |
| mode | input | 2 | Timing mode, latched at start: 00 fixed, 01 long reference, 10 leading zero, 11 one-of-four |
| start | input | 1 | Command start request, honoured only while idle |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Symbol accepted on this edge when valid |
| sym_val | input | 2 | Symbol value (bit 0 only outside one-of-four mode) |
| sym_last | input | 1 | Marks the final symbol of the command |
| field_en | output | 1 | Reader field enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when the command ends |

## Verification
The hardest situation to reach is a start request arriving mid-command with a different mode. If that request were wrongly honoured, the only visible effect would be an extra 1232-tick reference pulse. The stimulus pulses start with the long-reference code a few cycles into the power-up phase of a fixed-bit command and leaves the mode input changed. The scoreboard then requires the exact fixed-bit segment list. A second hard case is the tick strobe: it is slowed to one pulse in three for a one-of-four command, and the monitor counts ticks rather than cycles in every field segment.

// File: rtl/pim_pkg.sv
package pim_pkg;

   typedef enum logic [1:0] {
      DL_FIXED = 2'b00,
      DL_LREF  = 2'b01,
      DL_LZERO = 2'b10,
      DL_QUAD  = 2'b11
   } dl_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PWR,
      PH_SGAP,
      PH_LREF,
      PH_WAIT,
      PH_SYM,
      PH_WGAP
   } phase_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pim_symtime.sv
module pim_symtime
   import pim_pkg::*;
#(
   parameter int CW   = 13,
   parameter int T0   = 144,
   parameter int T1   = 400,
   parameter int T1LZ = 320,
   parameter int Q01  = 272,
   parameter int Q10  = 400,
   parameter int Q11  = 528
) (
   input  dl_mode_e      mode,
   input  logic [1:0]    sym,
   output logic [CW-1:0] dur
);

   always_comb begin
      unique case (mode)
         DL_QUAD: begin
            unique case (sym)
               2'b00:   dur = CW'(T0);
               2'b01:   dur = CW'(Q01);
               2'b10:   dur = CW'(Q10);
               default: dur = CW'(Q11);
            endcase
         end
         DL_LZERO: dur = sym[0] ? CW'(T1LZ) : CW'(T0);
         default:  dur = sym[0] ? CW'(T1)   : CW'(T0);
      endcase
   end

endmodule

// File: rtl/pim_downcnt.sv
module pim_downcnt #(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          fin
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= load_val;
      else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign fin = tick && (cnt_q == CW'(1));

endmodule

// File: rtl/pim_seq.sv
module pim_seq
   import pim_pkg::*;
#(
   parameter int CW     = 13,
   parameter int PWR_T  = 5000,
   parameter int SGAP_T = 248,
   parameter int WGAP_T = 160,
   parameter int LREF_T = 1232
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic          sym_valid,
   input  logic          sym_last,
   input  logic [CW-1:0] sym_dur,
   input  logic          fin,
   output phase_e        phase,
   output dl_mode_e      mode_q,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          ready,
   output logic          done,
   output logic          park
);

   phase_e nxt;
   logic   last_q;
   logic   take;

   assign take = ready && sym_valid;

   always_comb begin
      nxt      = phase;
      load     = 1'b0;
      load_val = '0;
      ready    = 1'b0;
      unique case (phase)
         PH_IDLE: if (start) begin
            nxt = PH_PWR; load = 1'b1; load_val = CW'(PWR_T);
         end
         PH_PWR: if (fin) begin
            nxt = PH_SGAP; load = 1'b1; load_val = CW'(SGAP_T);
         end
         PH_SGAP: if (fin) begin
            if (mode_q == DL_LREF) begin
               nxt = PH_LREF; load = 1'b1; load_val = CW'(LREF_T);
            end else begin
               ready = 1'b1;
               if (sym_valid) begin
                  nxt = PH_SYM; load = 1'b1; load_val = sym_dur;
               end else begin
                  nxt = PH_WAIT;
               end
            end
         end
         PH_LREF: if (fin) begin
            nxt = PH_WGAP; load = 1'b1; load_val = CW'(WGAP_T);
         end
         PH_WAIT: begin
            ready = 1'b1;
            if (sym_valid) begin
               nxt = PH_SYM; load = 1'b1; load_val = sym_dur;
            end
         end
         PH_SYM: if (fin) begin
            nxt = PH_WGAP; load = 1'b1; load_val = CW'(WGAP_T);
         end
         PH_WGAP: if (fin) begin
            if (last_q) begin
               nxt = PH_IDLE;
            end else begin
               ready = 1'b1;
               if (sym_valid) begin
                  nxt = PH_SYM; load = 1'b1; load_val = sym_dur;
               end else begin
                  nxt = PH_WAIT;
               end
            end
         end
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         mode_q <= DL_FIXED;
         last_q <= 1'b0;
         done   <= 1'b0;
         park   <= 1'b0;
      end else begin
         phase <= nxt;
         done  <= (phase == PH_WGAP) && fin && last_q;
         if (phase == PH_IDLE && start) begin
            mode_q <= dl_mode_e'(mode);
            last_q <= 1'b0;
            park   <= 1'b0;
         end
         if (take) last_q <= sym_last;
         if (phase == PH_WGAP && fin && last_q) park <= 1'b1;
      end
   end

endmodule

// File: rtl/pim_downlink.sv
module pim_downlink
   import pim_pkg::*;
#(
   parameter int UNIT_US   = 8,
   parameter int PWRUP_US  = 5000,
   parameter int SGAP_U    = 31,
   parameter int WGAP_U    = 20,
   parameter int T0_U      = 18,
   parameter int T1_U      = 50,
   parameter int T1LZ_U    = 40,
   parameter int Q01_U     = 34,
   parameter int Q10_U     = 50,
   parameter int Q11_U     = 66,
   parameter int LREF_X_U  = 136
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic [1:0] mode,
   input  logic       start,
   input  logic       sym_valid,
   output logic       sym_ready,
   input  logic [1:0] sym_val,
   input  logic       sym_last,
   output logic       field_en,
   output logic       busy,
   output logic       done
);

   localparam int SGAP_T = SGAP_U * UNIT_US;
   localparam int WGAP_T = WGAP_U * UNIT_US;
   localparam int T0_T   = T0_U * UNIT_US;
   localparam int T1_T   = T1_U * UNIT_US;
   localparam int T1LZ_T = T1LZ_U * UNIT_US;
   localparam int Q01_T  = Q01_U * UNIT_US;
   localparam int Q10_T  = Q10_U * UNIT_US;
   localparam int Q11_T  = Q11_U * UNIT_US;
   localparam int LREF_T = T0_T + LREF_X_U * UNIT_US;
   localparam int MAX_T  = imax(imax(imax(PWRUP_US, LREF_T), imax(SGAP_T, WGAP_T)),
                                imax(imax(T1_T, T1LZ_T), imax(Q10_T, Q11_T)));
   localparam int CW     = $clog2(MAX_T + 1);

   initial begin : elab_chk
      assert (UNIT_US > 0 && PWRUP_US > 0 && SGAP_U > 0 && WGAP_U > 0 && T0_U > 0)
         else $fatal(1, "pim_downlink: durations must be positive");
      assert (T1_U > 0 && T1LZ_U > 0 && Q01_U > 0 && Q10_U > 0 && Q11_U > 0)
         else $fatal(1, "pim_downlink: symbol times must be positive");
      assert (CW >= 2 && CW <= 31)
         else $fatal(1, "pim_downlink: counter width out of range");
   end

   phase_e        phase;
   dl_mode_e      mode_q;
   logic          load;
   logic [CW-1:0] load_val;
   logic [CW-1:0] sym_dur;
   logic          fin;
   logic          park;

   pim_symtime #(
      .CW(CW), .T0(T0_T), .T1(T1_T), .T1LZ(T1LZ_T),
      .Q01(Q01_T), .Q10(Q10_T), .Q11(Q11_T)
   ) u_symtime (
      .mode (mode_q),
      .sym  (sym_val),
      .dur  (sym_dur)
   );

   pim_downcnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .tick     (tick_us),
      .fin      (fin)
   );

   pim_seq #(
      .CW(CW), .PWR_T(PWRUP_US), .SGAP_T(SGAP_T),
      .WGAP_T(WGAP_T), .LREF_T(LREF_T)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .sym_valid (sym_valid),
      .sym_last  (sym_last),
      .sym_dur   (sym_dur),
      .fin       (fin),
      .phase     (phase),
      .mode_q    (mode_q),
      .load      (load),
      .load_val  (load_val),
      .ready     (sym_ready),
      .done      (done),
      .park      (park)
   );

   assign busy     = (phase != PH_IDLE);
   assign field_en = (phase == PH_PWR) || (phase == PH_LREF) || (phase == PH_SYM) ||
                     ((phase == PH_IDLE) && park);

endmodule

// File: rtl/pim_downlink_chk.sv
module pim_downlink_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_us,
   input logic start,
   input logic sym_ready,
   input logic field_en,
   input logic busy,
   input logic done
);

   a_r2_power_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> field_en);

   a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_us && !sym_ready) |=> $stable(field_en));

   a_r9_ready_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sym_ready |-> busy);

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_idle_field: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && field_en));

   a_r10_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind pim_downlink pim_downlink_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_us   (tick_us),
   .start     (start),
   .sym_ready (sym_ready),
   .field_en  (field_en),
   .busy      (busy),
   .done      (done)
);

// File: tb/pim_downlink_bench.sv
module pim_downlink_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       start = 1'b0;
   logic       sym_valid = 1'b0;
   logic [1:0] sym_val = 2'b00;
   logic       sym_last = 1'b0;
   logic       sym_ready, field_en, busy, done;
   logic       tick_us;

   int tick_div = 1;
   int tcnt = 0;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      bit    lvl;
      int    ticks;
      string req;
   } seg_t;

   seg_t       expq[$];
   logic [1:0] sv[16];
   bit         in_cmd = 0;
   bit         cur_lvl = 0;
   int         cur_ticks = 0;
   bit         cmd_end = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
   assign tick_us = (tcnt == 0);

   pim_downlink u_pim_downlink (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_us   (tick_us),
      .mode      (mode),
      .start     (start),
      .sym_valid (sym_valid),
      .sym_ready (sym_ready),
      .sym_val   (sym_val),
      .sym_last  (sym_last),
      .field_en  (field_en),
      .busy      (busy),
      .done      (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_on(input logic [1:0] m, input logic [1:0] s);
      case (m)
         2'b11:   return (s == 2'b00) ? 144 : (s == 2'b01) ? 272 : (s == 2'b10) ? 400 : 528;
         2'b10:   return s[0] ? 320 : 144;
         default: return s[0] ? 400 : 144;
      endcase
   endfunction

   task automatic close_seg();
      seg_t e;
      if (expq.size() == 0) begin
         check(0, "R3 unexpected segment", cur_ticks, 0);
      end else begin
         e = expq.pop_front();
         check(cur_lvl == e.lvl, e.req, int'(cur_lvl), int'(e.lvl));
         check(cur_ticks == e.ticks, e.req, cur_ticks, e.ticks);
      end
   endtask

   // monitor: measures field segments in ticks while busy
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            if (!in_cmd || field_en !== cur_lvl) begin
               if (in_cmd) close_seg();
               in_cmd    = 1;
               cur_lvl   = field_en;
               cur_ticks = 0;
            end
            if (tick_us) cur_ticks++;
         end else if (in_cmd) begin
            close_seg();
            in_cmd = 0;
            check(done === 1'b1, "R10 done at end", int'(done), 1);
            check(expq.size() == 0, "R3 leftover segments", expq.size(), 0);
            cmd_end = 1;
         end
      end
   end

   task automatic run_cmd(input logic [1:0] m, input int n, input bit poke, input string req);
      string sreq;
      expq.push_back('{1'b1, 5000, "R2 power-up on-time"});
      expq.push_back('{1'b0, 248, "R2 start gap"});
      if (m == 2'b01) begin
         expq.push_back('{1'b1, 1232, "R7 long reference"});
         expq.push_back('{1'b0, 160, "R7 gap after reference"});
      end
      for (int i = 0; i < n; i++) begin
         sreq = $sformatf("%s symbol %0d on-time", req, i);
         expq.push_back('{1'b1, exp_on(m, sv[i]), sreq});
         expq.push_back('{1'b0, 160, "R3 write gap"});
      end
      cmd_end = 0;
      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
      check(field_en === 1'b1, "R2 field on after start", int'(field_en), 1);
      check(sym_ready === 1'b0, "R9 no ready in power-up", int'(sym_ready), 0);
      if (poke) begin
         repeat (5) @(negedge clk);
         mode  = 2'b01;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(busy === 1'b1 && field_en === 1'b1, "R11 start while busy", int'(busy), 1);
      end
      for (int i = 0; i < n; i++) begin
         sym_val   = sv[i];
         sym_last  = (i == n - 1);
         sym_valid = 1'b1;
         while (!sym_ready) @(negedge clk);
         if (i == 0) check(field_en === 1'b0, "R9 ready at gap end", int'(field_en), 0);
         @(negedge clk);
      end
      sym_valid = 1'b0;
      sym_last  = 1'b0;
      while (!cmd_end) @(negedge clk);
      @(negedge clk);
      check(done === 1'b0, "R10 done single cycle", int'(done), 0);
      check(field_en === 1'b1, "R10 field kept on", int'(field_en), 1);
      check(sym_ready === 1'b0, "R9 no ready when idle", int'(sym_ready), 0);
      repeat (20) @(negedge clk);
      check(field_en === 1'b1 && busy === 1'b0, "R10 field held while idle", int'(field_en), 1);
   endtask

   initial begin : wdog
      repeat (WDOG_CYC) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", WDOG_CYC, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : drive
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(field_en === 1'b0, "R1 field after reset", int'(field_en), 0);
      check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
      check(done === 1'b0, "R1 done after reset", int'(done), 0);
      check(sym_ready === 1'b0, "R1 ready after reset", int'(sym_ready), 0);

      // R4 fixed-bit
      sv[0] = 2'b00; sv[1] = 2'b01; sv[2] = 2'b11; sv[3] = 2'b10;
      run_cmd(2'b00, 4, 0, "R4");

      // R7 long reference
      sv[0] = 2'b01; sv[1] = 2'b00;
      run_cmd(2'b01, 2, 0, "R7");

      // R5 leading zero, bit 1 ignored
      sv[0] = 2'b10; sv[1] = 2'b01; sv[2] = 2'b11;
      run_cmd(2'b10, 3, 0, "R5");

      // R6 one-of-four, all four values
      sv[0] = 2'b00; sv[1] = 2'b01; sv[2] = 2'b10; sv[3] = 2'b11;
      run_cmd(2'b11, 4, 0, "R6");

      // R11 start and mode change while busy are ignored
      sv[0] = 2'b01;
      run_cmd(2'b00, 1, 1, "R11");

      // R8 sparse tick strobe
      tick_div = 3;
      sv[0] = 2'b11; sv[1] = 2'b01;
      run_cmd(2'b11, 2, 0, "R8");
      tick_div = 1;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule